// File: doc/BRIEF.md
# Hardware Breakpoint Match Unit

This block watches every access a processor core makes and compares it against four programmable breakpoint slots. Each access on the watched bus carries a linear or port address, a transfer kind (instruction fetch, data read, data write, port input or port output) and a valid strobe. When an armed slot matches both the address, within the slot's length window, and the kind of access it was set for, the block records which slot fired in a sticky status register. One cycle later it raises a single-cycle trap request toward the exception logic.

Software programs the unit through a small register port that only the most privileged ring may use. The port reaches the four slot address registers, a control register that holds each slot's enables, access kind and length, the status register, and an extension register. The extension register holds the bit that allows port-I/O breakpoints. Requests from any other ring are refused and flagged. Exception delivery, stack frames and general-detect fault handling live outside this block.

Top module: `bkpt_match_unit`

## Requirements
- R1: After reset the slot addresses, control register and extension register read 0, the status register reads 0xFFFF_FFF0 and trap_req is low.
- R2: A register request with reg_priv other than 0 sets reg_err in the same cycle, returns reg_rdata 0 and changes no register. A request with reg_priv 0 leaves reg_err low.
- R3: Slot n is armed when control bit 2n (local enable) or control bit 2n+1 (global enable) is set. A slot with both bits clear never hits.
- R4: Slot n's access-kind code sits in control bits 16+4n..17+4n and its length code in control bits 18+4n..19+4n.
- R5: Length code 00 compares every address bit, 01 ignores address bit 0, 11 ignores address bits 1:0, and 10 makes the slot never hit.
- R6: Access-kind code 00 hits on instruction fetch only, 01 on data write only, 11 on data read or data write but never on fetch, and 10 on port input or port output. acc_kind encodes fetch=0, read=1, write=2, port in=3, port out=4; values 5 to 7 hit nothing.
- R7: Code 10 hits only while the extension register's bit 3 is set. That register stores only bit 3 and reads 0 in all other bits.
- R8: A hitting access sets status bit n (bits 0 to 3) for every slot n that hit it and leaves the other status bits unchanged. With no hit and no status write, the status bits hold.
- R9: Status bits 4 to 31 always read as 1.
- R10: Control bits 8, 9 and 13 are stored and read back but have no effect on matching. Control bits 10, 11, 12, 14 and 15 read 0.
- R11: Status hit bits are sticky. A status write loads bits 3:0 from reg_wdata, and a hit in the same cycle is ORed in on top.
- R12: trap_req is high in exactly the cycle after a valid access that hits at least one slot, and low otherwise.
- R13: reg_sel selects slot 0 to 3 with codes 0 to 3, control with 4, status with 5 and extension with 6; code 7 reads 0. A read returns its value combinationally while reg_en is high with reg_we low, and reg_rdata is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Watched access is present this cycle |
| acc_addr | input | ADDR_W | Linear or port address of the access |
| acc_kind | input | 3 | Access kind: 0 fetch, 1 read, 2 write, 3 port in, 4 port out |
| reg_en | input | 1 | Register port request |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_sel | input | 3 | Register select (see R13) |
| reg_priv | input | 2 | Ring of the requester; 0 is the most privileged |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data |
| reg_err | output | 1 | Request refused for privilege |
| trap_req | output | 1 | One-cycle debug trap request |

## Verification
The bench aims at the window edges of each length: the last byte inside a two- and four-byte window and the first byte past it. A wrong mask would fire there or miss there. It drives port accesses with the extension bit clear and then set, programs the undefined length code, and checks fetch against a read-or-write slot; a loose decoder would trap on all of these. It also hits two slots with a single access and lands a status clear in the same cycle as a hit. A design that priority-encodes hits, or lets the write win, then loses a status bit.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

   // Kinds of access seen on the watched bus
   typedef enum logic [2:0] {
      ACC_FETCH = 3'd0,
      ACC_READ  = 3'd1,
      ACC_WRITE = 3'd2,
      ACC_PIN   = 3'd3,
      ACC_POUT  = 3'd4
   } acc_kind_e;

   // Per-slot access-kind code
   typedef enum logic [1:0] {
      TYP_FETCH = 2'b00,
      TYP_WR    = 2'b01,
      TYP_PORT  = 2'b10,
      TYP_RW    = 2'b11
   } bp_type_e;

   // Per-slot length code
   typedef enum logic [1:0] {
      LEN_1     = 2'b00,
      LEN_2     = 2'b01,
      LEN_UNDEF = 2'b10,
      LEN_4     = 2'b11
   } bp_len_e;

   typedef struct packed {
      logic     armed;
      bp_type_e typ;
      bp_len_e  len;
   } slot_cfg_t;

   localparam int          REG_W          = 32;
   localparam int          SEL_W          = 3;
   localparam int          PRIV_W         = 2;
   localparam int          MAX_SLOTS      = 4;
   localparam int          STAT_HIT_W     = MAX_SLOTS;
   localparam int          CTRL_FIELD_LSB = 16;
   localparam int          CTRL_FIELD_W   = 4;
   localparam int          EXT_DE_BIT     = 3;
   localparam logic [31:0] CTRL_KEEP_MASK = 32'hFFFF_23FF;

   localparam logic [SEL_W-1:0]  SEL_CTRL = 3'd4;
   localparam logic [SEL_W-1:0]  SEL_STAT = 3'd5;
   localparam logic [SEL_W-1:0]  SEL_EXT  = 3'd6;
   localparam logic [PRIV_W-1:0] PRIV_TOP = 2'd0;

   // Pull one slot's enables and fields out of the control word
   function automatic slot_cfg_t decode_slot(input logic [REG_W-1:0] ctrl, input int idx);
      slot_cfg_t c;
      c.armed = ctrl[2*idx] | ctrl[2*idx+1];
      c.typ   = bp_type_e'(ctrl[CTRL_FIELD_LSB + CTRL_FIELD_W*idx +: 2]);
      c.len   = bp_len_e'(ctrl[CTRL_FIELD_LSB + CTRL_FIELD_W*idx + 2 +: 2]);
      return c;
   endfunction

endpackage

// File: rtl/bkpt_regfile.sv
module bkpt_regfile
   import bkpt_pkg::*;
#(
   parameter int NUM_SLOTS = 4,
   parameter int ADDR_W    = 32,
   parameter int RDATA_REG = 0
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              reg_en,
   input  logic                              reg_we,
   input  logic [SEL_W-1:0]                  reg_sel,
   input  logic [PRIV_W-1:0]                 reg_priv,
   input  logic [REG_W-1:0]                  reg_wdata,
   input  logic [REG_W-1:0]                  status_view,
   output logic [NUM_SLOTS-1:0][ADDR_W-1:0]  slot_addr,
   output logic [REG_W-1:0]                  ctrl_q,
   output logic                              ext_de,
   output logic                              status_wr,
   output logic [REG_W-1:0]                  reg_rdata,
   output logic                              reg_err
);

   logic             granted;
   logic             wr_ok;
   logic             rd_ok;
   logic [REG_W-1:0] rd_mux;

   assign granted   = reg_en && (reg_priv == PRIV_TOP);
   assign wr_ok     = granted && reg_we;
   assign rd_ok     = granted && !reg_we;
   assign reg_err   = reg_en && !granted;
   assign status_wr = wr_ok && (reg_sel == SEL_STAT);

   // One address register per slot
   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot_addr[g] <= '0;
         else if (wr_ok && (reg_sel == SEL_W'(g)))
            slot_addr[g] <= reg_wdata[ADDR_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl_q <= '0;
      else if (wr_ok && (reg_sel == SEL_CTRL))
         ctrl_q <= reg_wdata & CTRL_KEEP_MASK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ext_de <= 1'b0;
      else if (wr_ok && (reg_sel == SEL_EXT))
         ext_de <= reg_wdata[EXT_DE_BIT];
   end

   always_comb begin
      rd_mux = '0;
      if (rd_ok) begin
         case (reg_sel)
            SEL_CTRL: rd_mux = ctrl_q;
            SEL_STAT: rd_mux = status_view;
            SEL_EXT:  rd_mux = REG_W'(ext_de) << EXT_DE_BIT;
            default: begin
               for (int i = 0; i < NUM_SLOTS; i++)
                  if (reg_sel == SEL_W'(i))
                     rd_mux = REG_W'(slot_addr[i]);
            end
         endcase
      end
   end

   // Read path: combinational or one register stage
   if (RDATA_REG != 0) begin : g_rd_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            reg_rdata <= '0;
         else
            reg_rdata <= rd_mux;
      end
   end else begin : g_rd_comb
      assign reg_rdata = rd_mux;
   end

endmodule

// File: rtl/bkpt_slot_cmp.sv
module bkpt_slot_cmp
   import bkpt_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] slot_addr,
   input  slot_cfg_t         cfg,
   input  logic              ext_de,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  acc_kind_e         acc_kind,
   output logic              hit
);

   logic [ADDR_W-1:0] care;
   logic              len_ok;
   logic              kind_ok;
   logic              addr_eq;

   // Length picks which low address bits take part in the compare
   always_comb begin
      care   = '1;
      len_ok = 1'b1;
      case (cfg.len)
         LEN_1: care = '1;
         LEN_2: care = {{(ADDR_W-1){1'b1}}, 1'b0};
         LEN_4: care = {{(ADDR_W-2){1'b1}}, 2'b00};
         default: begin
            care   = '0;
            len_ok = 1'b0;
         end
      endcase
   end

   always_comb begin
      case (cfg.typ)
         TYP_FETCH: kind_ok = (acc_kind == ACC_FETCH);
         TYP_WR:    kind_ok = (acc_kind == ACC_WRITE);
         TYP_PORT:  kind_ok = ext_de && ((acc_kind == ACC_PIN) || (acc_kind == ACC_POUT));
         default:   kind_ok = (acc_kind == ACC_READ) || (acc_kind == ACC_WRITE);
      endcase
   end

   assign addr_eq = (((acc_addr ^ slot_addr) & care) == '0);
   assign hit     = acc_valid && cfg.armed && len_ok && kind_ok && addr_eq;

endmodule

// File: rtl/bkpt_status.sv
module bkpt_status
   import bkpt_pkg::*;
#(
   parameter int NUM_SLOTS = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_SLOTS-1:0]  hits,
   input  logic                  status_wr,
   input  logic [REG_W-1:0]      wdata,
   output logic [STAT_HIT_W-1:0] hit_bits,
   output logic [REG_W-1:0]      status_view,
   output logic                  trap_req
);

   logic [STAT_HIT_W-1:0] hits_wide;
   logic [STAT_HIT_W-1:0] base;

   assign hits_wide = STAT_HIT_W'(hits);
   assign base      = status_wr ? wdata[STAT_HIT_W-1:0] : hit_bits;

   // Sticky record; a hit always survives a same-cycle software write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_bits <= '0;
         trap_req <= 1'b0;
      end else begin
         hit_bits <= base | hits_wide;
         trap_req <= |hits;
      end
   end

   assign status_view = {{(REG_W-STAT_HIT_W){1'b1}}, hit_bits};

endmodule

// File: rtl/bkpt_match_unit.sv
module bkpt_match_unit
   import bkpt_pkg::*;
#(
   parameter int NUM_SLOTS = 4,
   parameter int ADDR_W    = 32,
   parameter int RDATA_REG = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [2:0]        acc_kind,
   input  logic              reg_en,
   input  logic              reg_we,
   input  logic [2:0]        reg_sel,
   input  logic [1:0]        reg_priv,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              reg_err,
   output logic              trap_req
);

   // Elaboration-time parameter checks
   if (NUM_SLOTS < 1 || NUM_SLOTS > MAX_SLOTS) begin : g_bad_slots
      $error("NUM_SLOTS must be 1..4");
   end
   if (ADDR_W < 2 || ADDR_W > REG_W) begin : g_bad_addr
      $error("ADDR_W must be 2..32");
   end

   logic [NUM_SLOTS-1:0][ADDR_W-1:0] slot_addr;
   logic [REG_W-1:0]                 ctrl_q;
   logic                             ext_de;
   logic                             status_wr;
   logic [REG_W-1:0]                 status_view;
   logic [STAT_HIT_W-1:0]            hit_bits;
   logic [NUM_SLOTS-1:0]             hits;
   acc_kind_e                        kind_e;

   assign kind_e = acc_kind_e'(acc_kind);

   bkpt_regfile #(
      .NUM_SLOTS (NUM_SLOTS),
      .ADDR_W    (ADDR_W),
      .RDATA_REG (RDATA_REG)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .reg_en      (reg_en),
      .reg_we      (reg_we),
      .reg_sel     (reg_sel),
      .reg_priv    (reg_priv),
      .reg_wdata   (reg_wdata),
      .status_view (status_view),
      .slot_addr   (slot_addr),
      .ctrl_q      (ctrl_q),
      .ext_de      (ext_de),
      .status_wr   (status_wr),
      .reg_rdata   (reg_rdata),
      .reg_err     (reg_err)
   );

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cmp
      slot_cfg_t cfg;
      assign cfg = decode_slot(ctrl_q, g);

      bkpt_slot_cmp #(
         .ADDR_W (ADDR_W)
      ) u_cmp (
         .slot_addr (slot_addr[g]),
         .cfg       (cfg),
         .ext_de    (ext_de),
         .acc_valid (acc_valid),
         .acc_addr  (acc_addr),
         .acc_kind  (kind_e),
         .hit       (hits[g])
      );
   end

   bkpt_status #(
      .NUM_SLOTS (NUM_SLOTS)
   ) u_status (
      .clk         (clk),
      .rst_n       (rst_n),
      .hits        (hits),
      .status_wr   (status_wr),
      .wdata       (reg_wdata),
      .hit_bits    (hit_bits),
      .status_view (status_view),
      .trap_req    (trap_req)
   );

endmodule

// File: rtl/bkpt_match_unit_chk.sv
module bkpt_match_unit_chk #(
   parameter int RDATA_REG = 0
) (
   input logic        clk,
   input logic        rst_n,
   input logic        acc_valid,
   input logic [2:0]  acc_kind,
   input logic        reg_en,
   input logic        reg_we,
   input logic [2:0]  reg_sel,
   input logic [1:0]  reg_priv,
   input logic [31:0] reg_rdata,
   input logic        trap_req,
   input logic [31:0] ctrl_q,
   input logic        ext_de,
   input logic [3:0]  hit_bits
);

   logic stat_write;
   logic stat_read;
   logic port_kind;

   assign stat_write = reg_en && reg_we && (reg_priv == 2'd0) && (reg_sel == 3'd5);
   assign stat_read  = reg_en && !reg_we && (reg_priv == 2'd0) && (reg_sel == 3'd5);
   assign port_kind  = (acc_kind == 3'd3) || (acc_kind == 3'd4);

   AST_TRAP_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> $past(acc_valid)); // R12

   AST_TRAP_RECORDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> (hit_bits != 4'd0)); // R8

   AST_STATUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_valid && !stat_write) |=> $stable(hit_bits)); // R8

   AST_PORT_NEEDS_EXT: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_req && $past(port_kind)) |-> $past(ext_de)); // R7

   AST_PRIV_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_en && reg_we && (reg_priv != 2'd0)) |=> ($stable(ctrl_q) && $stable(ext_de))); // R2

   AST_HITS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_write |=> ((hit_bits & $past(hit_bits)) == $past(hit_bits))); // R11

   if (RDATA_REG == 0) begin : g_comb_rd
      AST_RESERVED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
         stat_read |-> (&reg_rdata[31:4])); // R9
   end else begin : g_flop_rd
      AST_RESERVED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
         stat_read |=> (&reg_rdata[31:4])); // R9
   end

endmodule

bind bkpt_match_unit bkpt_match_unit_chk #(.RDATA_REG(RDATA_REG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .acc_valid (acc_valid),
   .acc_kind  (acc_kind),
   .reg_en    (reg_en),
   .reg_we    (reg_we),
   .reg_sel   (reg_sel),
   .reg_priv  (reg_priv),
   .reg_rdata (reg_rdata),
   .trap_req  (trap_req),
   .ctrl_q    (ctrl_q),
   .ext_de    (ext_de),
   .hit_bits  (hit_bits)
);

// File: tb/bkpt_match_unit_tb.sv
`timescale 1ns/1ps
module bkpt_match_unit_tb;

   localparam int K_FETCH = 0, K_READ = 1, K_WRITE = 2, K_PIN = 3, K_POUT = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_addr = '0;
   logic [2:0]  acc_kind = '0;
   logic        reg_en = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_sel = '0;
   logic [1:0]  reg_priv = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        reg_err;
   logic        trap_req;

   int n_chk = 0;
   int n_fail = 0;

   // Behavioural reference state
   longint unsigned m_slot[4];
   longint unsigned m_ctrl, m_ext, m_st;
   bit              m_trap;

   bit              dir_on = 0;
   longint unsigned dir_val;
   string           dir_tag;

   always #2 clk = ~clk;

   bkpt_match_unit u_dut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
      .acc_kind(acc_kind), .reg_en(reg_en), .reg_we(reg_we), .reg_sel(reg_sel),
      .reg_priv(reg_priv), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .reg_err(reg_err), .trap_req(trap_req)
   );

   task automatic chk(input bit ok, input string tag, input longint unsigned act,
                      input longint unsigned exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   function automatic longint unsigned m_read(input int sel);
      case (sel)
         0, 1, 2, 3: return m_slot[sel];
         4: return m_ctrl;
         5: return m_st | 64'hFFFF_FFF0;
         6: return m_ext;
         default: return 0;
      endcase
   endfunction

   // Range-based view of a slot: does [base, base+size) hold the address?
   function automatic bit m_match(input int n, input longint unsigned a, input int kind);
      longint unsigned size, base, typ, len;
      bit ok;
      if (((m_ctrl >> (2*n)) & 3) == 0) return 0;
      typ = (m_ctrl >> (16 + 4*n)) & 3;
      len = (m_ctrl >> (18 + 4*n)) & 3;
      size = (len == 0) ? 1 : (len == 1) ? 2 : (len == 3) ? 4 : 0;
      if (size == 0) return 0;
      case (typ)
         0: ok = (kind == K_FETCH);
         1: ok = (kind == K_WRITE);
         2: ok = ((kind == K_PIN) || (kind == K_POUT)) && (m_ext != 0);
         default: ok = (kind == K_READ) || (kind == K_WRITE);
      endcase
      base = m_slot[n] - (m_slot[n] % size);
      return ok && (a >= base) && (a < base + size);
   endfunction

   // One clock: compare outputs, advance the reference model
   task automatic cycle();
      longint unsigned exp_rd;
      bit exp_err, st_wr, en, we;
      bit [3:0] hits;
      int sel;
      longint unsigned wd;
      #1;
      en = reg_en; we = reg_we; sel = reg_sel; wd = reg_wdata;
      exp_err = en && (reg_priv != 0);
      exp_rd = 0;
      if (en && !we && !exp_err) exp_rd = m_read(sel);
      chk(reg_err == exp_err, "R2 reg_err", reg_err, exp_err);
      chk(reg_rdata == exp_rd, "R13 read data", reg_rdata, exp_rd);
      chk(trap_req == m_trap, "R12 trap", trap_req, m_trap);
      if (dir_on) begin
         chk(reg_rdata == dir_val, dir_tag, reg_rdata, dir_val);
         dir_on = 0;
      end
      hits = '0;
      if (acc_valid)
         for (int n = 0; n < 4; n++) hits[n] = m_match(n, acc_addr, acc_kind);
      st_wr = en && we && !exp_err && (sel == 5);
      @(posedge clk);
      if (en && we && !exp_err) begin
         case (sel)
            0, 1, 2, 3: m_slot[sel] = wd;
            4: m_ctrl = wd & 64'hFFFF_23FF;
            6: m_ext = wd & 64'h8;
            default: ;
         endcase
      end
      m_st = (st_wr ? (wd & 15) : m_st) | hits;
      m_trap = (hits != 0);
      @(negedge clk);
   endtask

   task automatic idle_in();
      acc_valid = 0; reg_en = 0; reg_we = 0; reg_priv = 0;
   endtask

   task automatic wr(input int sel, input logic [31:0] d, input int priv = 0);
      reg_en = 1; reg_we = 1; reg_sel = 3'(sel); reg_wdata = d; reg_priv = 2'(priv);
      cycle(); idle_in();
   endtask

   task automatic rd(input int sel, input longint unsigned exp, input string tag,
                     input int priv = 0);
      reg_en = 1; reg_we = 0; reg_sel = 3'(sel); reg_priv = 2'(priv);
      dir_on = 1; dir_val = exp; dir_tag = tag;
      cycle(); idle_in();
   endtask

   task automatic acc(input logic [31:0] a, input int kind);
      acc_valid = 1; acc_addr = a; acc_kind = 3'(kind);
      cycle(); idle_in();
   endtask

   task automatic see_trap(input bit exp, input string tag);
      chk(trap_req == exp, tag, trap_req, exp);
   endtask

   initial begin
      #(4 * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      for (int i = 0; i < 4; i++) m_slot[i] = 0;
      m_ctrl = 0; m_ext = 0; m_st = 0; m_trap = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // Reset state
      see_trap(0, "R1 trap after reset");
      rd(5, 64'hFFFF_FFF0, "R1 R9 status after reset");
      rd(4, 0, "R1 control after reset");
      rd(2, 0, "R1 slot after reset");
      rd(6, 0, "R1 extension after reset");

      // Single-byte write breakpoint on slot 0 (global enable)
      wr(0, 32'h1000);
      wr(4, 32'h0001_0002);
      rd(4, 32'h0001_0002, "R4 control readback");
      acc(32'h1000, K_WRITE);  see_trap(1, "R12 write hit");
      rd(5, 64'hFFFF_FFF1, "R8 slot0 bit");
      acc(32'h1000, K_READ);   see_trap(0, "R6 read on write-only slot");
      acc(32'h1001, K_WRITE);  see_trap(0, "R5 one-byte neighbour");
      acc_valid = 0; acc_addr = 32'h1000; acc_kind = 3'(K_WRITE);
      cycle(); idle_in();      see_trap(0, "R12 no valid no trap");
      rd(5, 64'hFFFF_FFF1, "R11 sticky");
      wr(5, 0);
      rd(5, 64'hFFFF_FFF0, "R11 cleared");

      // Two-byte read-or-write on slot 1 (local enable)
      wr(1, 32'h2001);
      wr(4, 32'h0071_0006);
      acc(32'h2000, K_READ);   see_trap(1, "R5 two-byte low");
      acc(32'h2001, K_WRITE);  see_trap(1, "R5 two-byte high");
      acc(32'h2002, K_READ);   see_trap(0, "R5 two-byte past end");
      acc(32'h2000, K_FETCH);  see_trap(0, "R6 fetch on rw slot");
      rd(5, 64'hFFFF_FFF2, "R8 slot1 bit only");

      // Undefined length
      wr(4, 32'h00B1_0006);
      wr(5, 0);
      acc(32'h2000, K_READ);   see_trap(0, "R5 undefined length");
      acc(32'h2001, K_WRITE);  see_trap(0, "R5 undefined length");

      // Four-byte fetch on slot 2
      wr(2, 32'h3003);
      wr(4, 32'h0C00_0020);
      acc(32'h3000, K_FETCH);  see_trap(1, "R5 four-byte first");
      acc(32'h3003, K_FETCH);  see_trap(1, "R5 four-byte last");
      acc(32'h3004, K_FETCH);  see_trap(0, "R5 four-byte past end");
      acc(32'h3000, K_READ);   see_trap(0, "R6 read on fetch slot");

      // Port breakpoint on slot 3
      wr(5, 0);
      wr(3, 32'h01F7);
      wr(4, 32'h2000_0040);
      acc(32'h01F7, K_PIN);    see_trap(0, "R7 port with extension off");
      wr(6, 32'hFFFF);
      rd(6, 8, "R7 extension readback");
      acc(32'h01F7, K_PIN);    see_trap(1, "R7 port in");
      acc(32'h01F7, K_POUT);   see_trap(1, "R7 port out");
      acc(32'h01F7, K_WRITE);  see_trap(0, "R6 write on port slot");
      acc(32'h01F7, 7);        see_trap(0, "R6 undefined kind");
      rd(5, 64'hFFFF_FFF8, "R8 slot3 bit");

      // Two slots hit by one access
      wr(5, 0);
      wr(0, 32'h5000);
      wr(1, 32'h5000);
      wr(4, 32'h0033_0005);
      acc(32'h5000, K_WRITE);  see_trap(1, "R8 double hit trap");
      rd(5, 64'hFFFF_FFF3, "R8 double hit bits");

      // Disarmed slots
      wr(5, 0);
      wr(4, 32'h0033_0000);
      acc(32'h5000, K_WRITE);  see_trap(0, "R3 disarmed");
      rd(5, 64'hFFFF_FFF0, "R3 no status");

      // Stored-only control bits
      wr(4, 32'hFFFF_FFFF);
      rd(4, 32'hFFFF_23FF, "R10 control mask");
      wr(4, 32'h0033_2300);
      wr(5, 0);
      acc(32'h5000, K_WRITE);  see_trap(0, "R10 extra bits do not arm");
      wr(4, 32'h0033_2301);
      acc(32'h5000, K_WRITE);  see_trap(1, "R10 extra bits do not block");
      rd(5, 64'hFFFF_FFF1, "R10 slot0 only");

      // Privilege
      wr(4, 32'h0000_0000, 3);
      rd(4, 32'h0033_2301, "R2 control unchanged");
      rd(4, 0, "R2 unprivileged read", 1);

      // Status clear racing a hit
      reg_en = 1; reg_we = 1; reg_sel = 3'd5; reg_wdata = 0; reg_priv = 0;
      acc_valid = 1; acc_addr = 32'h5000; acc_kind = 3'(K_WRITE);
      cycle(); idle_in();
      rd(5, 64'hFFFF_FFF1, "R11 hit beats clear");

      // Select map
      rd(7, 0, "R13 unused select");
      rd(0, 32'h5000, "R13 slot0 select");

      // Randomised traffic against the model
      for (int it = 0; it < 4000; it++) begin
         int r;
         r = int'($urandom % 8);
         if (r == 0) begin
            reg_en = 1; reg_we = 1; reg_sel = 3'($urandom % 8);
            reg_priv = 2'(($urandom % 4 == 0) ? ($urandom % 4) : 0);
            reg_wdata = (reg_sel < 4) ? (32'h100 + ($urandom % 16)) : $urandom;
         end else if (r == 1) begin
            reg_en = 1; reg_we = 0; reg_sel = 3'($urandom % 8);
            reg_priv = 2'(($urandom % 4 == 0) ? ($urandom % 4) : 0);
         end
         acc_valid = ($urandom % 4) != 0;
         acc_addr = 32'h100 + ($urandom % 20);
         acc_kind = 3'($urandom % 6);
         cycle(); idle_in();
      end

      summary();
      $finish;
   end

endmodule